// File: doc/BRIEF.md
# Two-Channel Input Capture Timer

This block timestamps events on a bank of external input pins. A single free-standing counter, advanced by a tick-enable strobe from an outside prescaler, gives the time base. The counter can run from every clock down to one step per 256 clocks. Two channels each watch two events, a start event and a stop event. Each event has its own pin selector and edge qualifier. Every event latches the current count into its own capture register and raises a sticky flag. The same events can also gate the counter, depending on the run mode.

All pins are first passed through a two-flop synchronizer and then through an edge detector, so asynchronous signals can be connected directly. Software-side control is plain level and pulse inputs:
- a counter clear and a counter start;
- a write-one acknowledge for each flag;
- interrupt enables that merge the flags into one interrupt line.

A typical pulse-width measurement uses the gated mode. The start event is the rising edge of a pin and the stop event is the falling edge of the same pin. The counter then holds the width, and the stop capture holds the width minus one.

Top module: `icap_timer`

## Requirements
- R1: After reset the count, all capture registers, all flags and the interrupt line are 0, and the counter is not running.
- R2: A pin transition that occurs before rising clock edge k becomes visible in its event flag and capture register after edge k+2, and not earlier.
- R3: Each event's 2-bit edge qualifier selects the trigger: 0 = never, 1 = rising edge only, 2 = falling edge only, 3 = either edge.
- R4: Each event's 4-bit pin selector chooses one of the 16 pins by its index; transitions on every other pin have no effect on that event.
- R5: In run mode 0 (free), the count increases by exactly one at each edge where tick is 1, and holds where tick is 0.
- R6: In run mode 1 (gated), a start event from a gating channel starts the counter, and a stop event from a gating channel halts it. For a pulse of width W cycles measured with start on the rising edge and stop on the falling edge of one pin, after a clear the count ends at W, the start capture at 0 and the stop capture at W-1.
- R7: In run mode 2 (run until stop), the counter is started only by software start, start events do not affect it, and a stop event from a gating channel halts it.
- R8: In run mode 3 (hold), the count never changes except by software clear.
- R9: An event loads its capture register and sets its flag only while that flag is clear. A set flag and its held capture value persist until a 1 is written to the matching acknowledge bit, which clears the flag one edge later.
- R10: When the count is 16'hFFFF and advances, it wraps to 0 and sets the sticky overflow flag, which is cleared by its write-one acknowledge.
- R11: Software clear forces the count to 0 at the next edge, taking priority over a tick. Software start issued together with clear leaves the counter at 0 and running.
- R12: The interrupt line is the OR of every flag ANDed with its enable bit; a set flag with its enable at 0 leaves the line low.
- R13: A channel whose gate-enable bit is 0 still captures and flags its events but never starts or stops the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Count enable strobe from the prescaler |
| pins_in | input | 16 | Asynchronous event pins |
| run_mode | input | 2 | 0 free, 1 gated, 2 run until stop, 3 hold |
| sw_clear | input | 1 | Clear the counter at the next edge |
| sw_start | input | 1 | Set the run state at the next edge |
| gate_en | input | 2 | Per channel: its events may start/stop the counter |
| start_sel | input | 8 | Per channel 4-bit pin index of the start event |
| start_edge | input | 4 | Per channel 2-bit edge qualifier of the start event |
| stop_sel | input | 8 | Per channel 4-bit pin index of the stop event |
| stop_edge | input | 4 | Per channel 2-bit edge qualifier of the stop event |
| start_ie | input | 2 | Per channel start flag interrupt enable |
| stop_ie | input | 2 | Per channel stop flag interrupt enable |
| ovf_ie | input | 1 | Overflow flag interrupt enable |
| start_ack | input | 2 | Per channel write-one clear of the start flag |
| stop_ack | input | 2 | Per channel write-one clear of the stop flag |
| ovf_ack | input | 1 | Write-one clear of the overflow flag |
| count | output | 16 | Current counter value |
| start_cap | output | 32 | Per channel 16-bit start capture, channel 0 in the low half |
| stop_cap | output | 32 | Per channel 16-bit stop capture, channel 0 in the low half |
| start_flag | output | 2 | Per channel sticky start flag |
| stop_flag | output | 2 | Per channel sticky stop flag |
| ovf_flag | output | 1 | Sticky overflow flag |
| irq | output | 1 | Merged interrupt request |

## Verification
A pin change made before edge k reaches its flag and capture after edge k+2. It affects the counter's run state at edge k+2, so the first or last extra step lands at edge k+3. Tick, clear, start and acknowledge each act at the very next edge, and the interrupt line follows the flags and enables in the same cycle. The bench drives every input on a falling edge and samples on a falling edge after counting the rising edges in between, so each expected value is read at the first cycle it is due. It also checks the cycle just before the flag is due, to show that the flag is not early. Expected counts and captures come from the bench's own tally of the ticks it has issued.

// File: rtl/icap_pkg.sv
package icap_pkg;

  typedef enum logic [1:0] {
    EDGE_NONE = 2'b00,
    EDGE_RISE = 2'b01,
    EDGE_FALL = 2'b10,
    EDGE_ANY  = 2'b11
  } edge_kind_t;

  typedef enum logic [1:0] {
    RUN_FREE    = 2'b00,
    RUN_GATED   = 2'b01,
    RUN_TO_STOP = 2'b10,
    RUN_HOLD    = 2'b11
  } run_mode_t;

endpackage

// File: rtl/icap_pin_sync.sv
module icap_pin_sync #(
  parameter int NUM_PINS = 16,
  parameter int STAGES   = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pins_in,
  output logic [NUM_PINS-1:0] rise,
  output logic [NUM_PINS-1:0] fall
);

  localparam int TOP = STAGES - 1;

  generate
    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
      logic [STAGES-1:0] chain;
      logic              last;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          chain <= '0;
          last  <= 1'b0;
        end else begin
          chain <= {chain[STAGES-2:0], pins_in[i]};
          last  <= chain[TOP];
        end
      end

      assign rise[i] = chain[TOP] & ~last;
      assign fall[i] = ~chain[TOP] & last;

      // R2: a detected rising edge reflects the pin value STAGES edges back
      assert_rise_src_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rise[i] |-> $past(pins_in[i], STAGES));
    end
  endgenerate

endmodule

// File: rtl/icap_event_sel.sv
module icap_event_sel
  import icap_pkg::*;
#(
  parameter int NUM_PINS = 16,
  parameter int SEL_W    = 4
) (
  input  logic [NUM_PINS-1:0] rise,
  input  logic [NUM_PINS-1:0] fall,
  input  logic [SEL_W-1:0]    sel,
  input  edge_kind_t          kind,
  output logic                hit
);

  logic r_sel;
  logic f_sel;

  always_comb begin
    r_sel = rise[sel];
    f_sel = fall[sel];
    case (kind)
      EDGE_RISE: hit = r_sel;
      EDGE_FALL: hit = f_sel;
      EDGE_ANY:  hit = r_sel | f_sel;
      default:   hit = 1'b0;
    endcase
  end

endmodule

// File: rtl/icap_counter.sv
module icap_counter
  import icap_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int NUM_CH = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  run_mode_t         mode,
  input  logic              sw_clear,
  input  logic              sw_start,
  input  logic [NUM_CH-1:0] gate_en,
  input  logic [NUM_CH-1:0] start_hit,
  input  logic [NUM_CH-1:0] stop_hit,
  input  logic              ovf_ack,
  output logic [CNT_W-1:0]  count,
  output logic              ovf_flag
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic run;
  logic run_n;
  logic gate_start;
  logic gate_stop;
  logic advance;
  logic wrap;

  assign gate_start = |(start_hit & gate_en);
  assign gate_stop  = |(stop_hit & gate_en);

  always_comb begin
    run_n = run;
    case (mode)
      RUN_GATED: begin
        if (gate_stop)                    run_n = 1'b0;
        else if (gate_start || sw_start)  run_n = 1'b1;
      end
      RUN_TO_STOP: begin
        if (gate_stop)      run_n = 1'b0;
        else if (sw_start)  run_n = 1'b1;
      end
      default: begin
        if (sw_start) run_n = 1'b1;
      end
    endcase
  end

  always_comb begin
    case (mode)
      RUN_FREE:               advance = tick;
      RUN_GATED, RUN_TO_STOP: advance = tick & run;
      default:                advance = 1'b0;
    endcase
  end

  assign wrap = advance & ~sw_clear & (count == CNT_MAX);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run      <= 1'b0;
      count    <= '0;
      ovf_flag <= 1'b0;
    end else begin
      run <= run_n;
      if (sw_clear)     count <= '0;
      else if (advance) count <= count + 1'b1;
      ovf_flag <= wrap | (ovf_flag & ~ovf_ack);
    end
  end

  assert_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == RUN_HOLD && !sw_clear) |=> $stable(count));

  assert_no_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !sw_clear) |=> $stable(count));

  assert_free_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == RUN_FREE && tick && !sw_clear) |=> count == CNT_W'($past(count) + 1'b1));

  assert_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    sw_clear |=> count == '0);

  assert_wrap_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (count == CNT_MAX && !sw_clear) |=> (count != '0 || ovf_flag));

endmodule

// File: rtl/icap_cap_slot.sv
module icap_cap_slot #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] count,
  input  logic             hit,
  input  logic             ack,
  output logic [CNT_W-1:0] cap,
  output logic             flag
);

  logic load;

  assign load = hit & (~flag | ack);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap  <= '0;
      flag <= 1'b0;
    end else begin
      if (load) cap <= count;
      flag <= hit | (flag & ~ack);
    end
  end

  assert_keep_cap_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !ack) |=> $stable(cap));

  assert_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !ack) |=> flag);

  assert_take_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (hit && !flag) |=> (flag && cap == $past(count)));

endmodule

// File: rtl/icap_timer.sv
module icap_timer
  import icap_pkg::*;
#(
  parameter int NUM_PINS = 16,
  parameter int NUM_CH   = 2,
  parameter int CNT_W    = 16,
  parameter int STAGES   = 2,
  localparam int SEL_W   = $clog2(NUM_PINS)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      tick,
  input  logic [NUM_PINS-1:0]       pins_in,
  input  logic [1:0]                run_mode,
  input  logic                      sw_clear,
  input  logic                      sw_start,
  input  logic [NUM_CH-1:0]         gate_en,
  input  logic [NUM_CH*SEL_W-1:0]   start_sel,
  input  logic [NUM_CH*2-1:0]       start_edge,
  input  logic [NUM_CH*SEL_W-1:0]   stop_sel,
  input  logic [NUM_CH*2-1:0]       stop_edge,
  input  logic [NUM_CH-1:0]         start_ie,
  input  logic [NUM_CH-1:0]         stop_ie,
  input  logic                      ovf_ie,
  input  logic [NUM_CH-1:0]         start_ack,
  input  logic [NUM_CH-1:0]         stop_ack,
  input  logic                      ovf_ack,
  output logic [CNT_W-1:0]          count,
  output logic [NUM_CH*CNT_W-1:0]   start_cap,
  output logic [NUM_CH*CNT_W-1:0]   stop_cap,
  output logic [NUM_CH-1:0]         start_flag,
  output logic [NUM_CH-1:0]         stop_flag,
  output logic                      ovf_flag,
  output logic                      irq
);

  logic [NUM_PINS-1:0] rise;
  logic [NUM_PINS-1:0] fall;
  logic [NUM_CH-1:0]   start_hit;
  logic [NUM_CH-1:0]   stop_hit;

  icap_pin_sync #(.NUM_PINS(NUM_PINS), .STAGES(STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .pins_in (pins_in),
    .rise    (rise),
    .fall    (fall)
  );

  generate
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      icap_event_sel #(.NUM_PINS(NUM_PINS), .SEL_W(SEL_W)) u_start_sel (
        .rise (rise),
        .fall (fall),
        .sel  (start_sel[c*SEL_W +: SEL_W]),
        .kind (edge_kind_t'(start_edge[c*2 +: 2])),
        .hit  (start_hit[c])
      );

      icap_event_sel #(.NUM_PINS(NUM_PINS), .SEL_W(SEL_W)) u_stop_sel (
        .rise (rise),
        .fall (fall),
        .sel  (stop_sel[c*SEL_W +: SEL_W]),
        .kind (edge_kind_t'(stop_edge[c*2 +: 2])),
        .hit  (stop_hit[c])
      );

      icap_cap_slot #(.CNT_W(CNT_W)) u_start_slot (
        .clk   (clk),
        .rst_n (rst_n),
        .count (count),
        .hit   (start_hit[c]),
        .ack   (start_ack[c]),
        .cap   (start_cap[c*CNT_W +: CNT_W]),
        .flag  (start_flag[c])
      );

      icap_cap_slot #(.CNT_W(CNT_W)) u_stop_slot (
        .clk   (clk),
        .rst_n (rst_n),
        .count (count),
        .hit   (stop_hit[c]),
        .ack   (stop_ack[c]),
        .cap   (stop_cap[c*CNT_W +: CNT_W]),
        .flag  (stop_flag[c])
      );
    end
  endgenerate

  icap_counter #(.CNT_W(CNT_W), .NUM_CH(NUM_CH)) u_counter (
    .clk       (clk),
    .rst_n     (rst_n),
    .tick      (tick),
    .mode      (run_mode_t'(run_mode)),
    .sw_clear  (sw_clear),
    .sw_start  (sw_start),
    .gate_en   (gate_en),
    .start_hit (start_hit),
    .stop_hit  (stop_hit),
    .ovf_ack   (ovf_ack),
    .count     (count),
    .ovf_flag  (ovf_flag)
  );

  assign irq = (|(start_flag & start_ie)) | (|(stop_flag & stop_ie)) | (ovf_flag & ovf_ie);

  // R12: no flag set means no interrupt
  assert_irq_quiet_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (start_flag == '0 && stop_flag == '0 && !ovf_flag) |-> !irq);

endmodule

// File: tb/icap_timer_test.sv
module icap_timer_test;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n, tick, sw_clear, sw_start, ovf_ie, ovf_ack;
  logic [15:0] pins;
  logic [1:0]  mode, gate_en, start_ie, stop_ie, start_ack, stop_ack;
  logic [3:0]  ssel [2];
  logic [3:0]  psel [2];
  logic [1:0]  sedg [2];
  logic [1:0]  pedg [2];
  logic [7:0]  start_sel_w, stop_sel_w;
  logic [3:0]  start_edge_w, stop_edge_w;

  logic [15:0] count;
  logic [31:0] start_cap, stop_cap;
  logic [1:0]  start_flag, stop_flag;
  logic        ovf_flag, irq;

  assign start_sel_w  = {ssel[1], ssel[0]};
  assign stop_sel_w   = {psel[1], psel[0]};
  assign start_edge_w = {sedg[1], sedg[0]};
  assign stop_edge_w  = {pedg[1], pedg[0]};

  icap_timer uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .pins_in(pins), .run_mode(mode),
    .sw_clear(sw_clear), .sw_start(sw_start), .gate_en(gate_en),
    .start_sel(start_sel_w), .start_edge(start_edge_w),
    .stop_sel(stop_sel_w), .stop_edge(stop_edge_w),
    .start_ie(start_ie), .stop_ie(stop_ie), .ovf_ie(ovf_ie),
    .start_ack(start_ack), .stop_ack(stop_ack), .ovf_ack(ovf_ack),
    .count(count), .start_cap(start_cap), .stop_cap(stop_cap),
    .start_flag(start_flag), .stop_flag(stop_flag), .ovf_flag(ovf_flag), .irq(irq)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic ack_all();
    start_ack = 2'b11;
    stop_ack  = 2'b11;
    cyc(1);
    start_ack = 2'b00;
    stop_ack  = 2'b00;
  endtask

  function automatic logic get_flag(input int ch, input int kind);
    return (kind == 0) ? start_flag[ch] : stop_flag[ch];
  endfunction

  function automatic logic [15:0] get_cap(input int ch, input int kind);
    return (kind == 0) ? start_cap[ch*16 +: 16] : stop_cap[ch*16 +: 16];
  endfunction

  task automatic edges_off();
    for (int c = 0; c < 2; c++) begin
      sedg[c] = 2'd0;
      pedg[c] = 2'd0;
    end
  endtask

  initial begin
    rst_n = 1'b0; tick = 1'b0; sw_clear = 1'b0; sw_start = 1'b0;
    ovf_ie = 1'b0; ovf_ack = 1'b0; pins = '0; mode = 2'd3; gate_en = 2'b00;
    start_ie = 2'b00; stop_ie = 2'b00; start_ack = 2'b00; stop_ack = 2'b00;
    for (int c = 0; c < 2; c++) begin
      ssel[c] = 4'd0; psel[c] = 4'd0; sedg[c] = 2'd0; pedg[c] = 2'd0;
    end
    cyc(3);
    rst_n = 1'b1;
    cyc(1);

    // R1 reset state
    check("R1 count", count, 0);
    check("R1 start_cap", start_cap, 0);
    check("R1 stop_cap", stop_cap, 0);
    check("R1 flags", {start_flag, stop_flag, ovf_flag}, 0);
    check("R1 irq", irq, 0);

    // R2 latency: change before edge k, visible after edge k+2
    ssel[0] = 4'd0; sedg[0] = 2'd1;
    cyc(1);
    pins[0] = 1'b1;
    cyc(2);
    check("R2 not early", start_flag[0], 0);
    cyc(1);
    check("R2 due", start_flag[0], 1);
    ack_all();
    pins[0] = 1'b0;
    cyc(3);
    ack_all();
    edges_off();

    // prepare count 9 for the sweep
    mode = 2'd0; sw_clear = 1'b1; tick = 1'b1;
    cyc(1);
    sw_clear = 1'b0;
    cyc(9);
    tick = 1'b0; mode = 2'd3;
    check("R5 preset", count, 9);

    // R3/R4 sweep over channel, event kind, pin and edge qualifier
    for (int ch = 0; ch < 2; ch++) begin
      for (int kind = 0; kind < 2; kind++) begin
        for (int p = 0; p < 16; p++) begin
          for (int e = 0; e < 4; e++) begin
            int q;
            logic on_rise;
            logic on_fall;
            q = (p + 5) % 16;
            on_rise = (e == 1) || (e == 3);
            on_fall = (e >= 2);
            edges_off();
            if (kind == 0) begin ssel[ch] = 4'(p); sedg[ch] = 2'(e); end
            else           begin psel[ch] = 4'(p); pedg[ch] = 2'(e); end
            cyc(1);
            pins[q] = 1'b1;
            cyc(3);
            check("R4 other pin", get_flag(ch, kind), 0);
            pins[p] = 1'b1;
            cyc(3);
            check("R3 rise", get_flag(ch, kind), on_rise);
            if (on_rise) check("R3 rise cap", get_cap(ch, kind), 9);
            ack_all();
            check("R9 ack clears", get_flag(ch, kind), 0);
            pins[p] = 1'b0;
            cyc(3);
            check("R3 fall", get_flag(ch, kind), on_fall);
            ack_all();
            pins[q] = 1'b0;
            cyc(3);
            ack_all();
          end
        end
      end
    end
    edges_off();

    // R9 capture held while flag set
    ssel[0] = 4'd5; sedg[0] = 2'd3;
    mode = 2'd0; sw_clear = 1'b1;
    cyc(1);
    sw_clear = 1'b0; tick = 1'b1;
    cyc(5);
    tick = 1'b0;
    pins[5] = 1'b1;
    cyc(3);
    check("R9 first cap", start_cap[15:0], 5);
    tick = 1'b1;
    cyc(3);
    tick = 1'b0;
    pins[5] = 1'b0;
    cyc(3);
    check("R9 held cap", start_cap[15:0], 5);
    check("R9 held flag", start_flag[0], 1);
    ack_all();
    pins[5] = 1'b1;
    cyc(3);
    check("R9 new cap", start_cap[15:0], 8);
    pins[5] = 1'b0;
    cyc(3);
    ack_all();
    edges_off();

    // R5 free run with irregular ticks
    begin
      int exp_cnt;
      sw_clear = 1'b1;
      cyc(1);
      sw_clear = 1'b0;
      exp_cnt = 0;
      for (int i = 0; i < 30; i++) begin
        tick = (i % 3) != 0;
        cyc(1);
        if (tick) exp_cnt++;
        check("R5 free count", count, exp_cnt);
      end
      tick = 1'b0;
      // R8 hold ignores ticks
      mode = 2'd3; tick = 1'b1;
      cyc(10);
      check("R8 hold", count, exp_cnt);
      tick = 1'b0;
    end

    // R6 gated pulse-width measurement
    mode = 2'd1; gate_en = 2'b01;
    ssel[0] = 4'd2; sedg[0] = 2'd1;
    psel[0] = 4'd2; pedg[0] = 2'd2;
    tick = 1'b1;
    for (int w = 1; w <= 10; w++) begin
      sw_clear = 1'b1; start_ack = 2'b11; stop_ack = 2'b11;
      cyc(1);
      sw_clear = 1'b0; start_ack = 2'b00; stop_ack = 2'b00;
      check("R6 idle", count, 0);
      pins[2] = 1'b1;
      cyc(w);
      pins[2] = 1'b0;
      cyc(6);
      check("R6 width", count, w);
      check("R6 start cap", start_cap[15:0], 0);
      check("R6 stop cap", stop_cap[15:0], w - 1);
      cyc(3);
      check("R6 halted", count, w);
    end
    tick = 1'b0;

    // R13 non-gating channel captures without touching the counter
    sw_clear = 1'b1;
    ack_all();
    sw_clear = 1'b0;
    ssel[1] = 4'd3; sedg[1] = 2'd1;
    tick = 1'b1;
    pins[3] = 1'b1;
    cyc(6);
    check("R13 count", count, 0);
    check("R13 flag", start_flag[1], 1);
    pins[3] = 1'b0; sedg[1] = 2'd0; tick = 1'b0;
    cyc(3);
    ack_all();

    // R7 run until stop
    mode = 2'd2; sw_clear = 1'b1;
    cyc(1);
    sw_clear = 1'b0; sw_start = 1'b1; tick = 1'b1;
    cyc(1);
    sw_start = 1'b0;
    cyc(4);
    check("R7 started", count, 4);
    pins[2] = 1'b1;
    cyc(3);
    check("R7 start ignored", count, 7);
    pins[2] = 1'b0;
    cyc(3);
    check("R7 stop edge", count, 10);
    cyc(4);
    check("R7 stopped", count, 10);
    tick = 1'b0;
    ack_all();

    // R11 clear and start together, clear over tick
    mode = 2'd1; tick = 1'b1; sw_clear = 1'b1; sw_start = 1'b1;
    cyc(1);
    sw_clear = 1'b0; sw_start = 1'b0;
    check("R11 cleared", count, 0);
    cyc(2);
    check("R11 running", count, 2);
    sw_clear = 1'b1;
    cyc(1);
    check("R11 clear wins", count, 0);
    sw_clear = 1'b0; mode = 2'd3; tick = 1'b0;

    // R12 interrupt enables
    ssel[0] = 4'd6; sedg[0] = 2'd1; pedg[0] = 2'd0;
    pins[6] = 1'b1;
    cyc(3);
    check("R12 flag", start_flag[0], 1);
    check("R12 masked", irq, 0);
    start_ie = 2'b01;
    #1;
    check("R12 enabled", irq, 1);
    start_ie = 2'b00; stop_ie = 2'b01;
    #1;
    check("R12 other enable", irq, 0);
    stop_ie = 2'b00;
    pins[6] = 1'b0;
    cyc(3);
    ack_all();
    edges_off();

    // R10 wrap and overflow flag
    mode = 2'd0; sw_clear = 1'b1;
    cyc(1);
    sw_clear = 1'b0; tick = 1'b1; ovf_ie = 1'b1;
    cyc(65535);
    check("R10 max", count, 16'hFFFF);
    check("R10 no flag yet", ovf_flag, 0);
    check("R10 irq low", irq, 0);
    cyc(1);
    check("R10 wrapped", count, 0);
    check("R10 flag", ovf_flag, 1);
    check("R10 irq", irq, 1);
    tick = 1'b0; ovf_ack = 1'b1;
    cyc(1);
    ovf_ack = 1'b0;
    check("R10 ack", ovf_flag, 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule